// File: doc/BRIEF.md
# Scan-Sampled Event Counter

This block is a counter of the kind a programmable controller provides as a ladder instruction. It watches two rung conditions, one that counts up and one that counts down. Once per scan tick, marked by a one-cycle `scan_en` pulse, it compares each rung with the value it held at the previous tick. Only a false-to-true change moves the count, so a rung held true for many scans adds a single count. A two-bit mode input selects one of three behaviours: up counting, down counting with a load-from-preset input, or combined up/down counting. Each behaviour has its own rule for the done bit.

The count is a signed 16-bit value that saturates instead of wrapping. A clear input zeroes the count in the up and up/down modes. A load input copies the preset into the count in down mode. Either one wins over a counting edge in the same scan. Longer totals come from chaining counters: one counter's done bit drives the next counter's up rung, and it can also drive the first counter's own clear input.

Each scan tick goes through three steps in order. First, the edge stage registers the rungs. Second, the decode stage picks one operation from the mode table: hold, clear, load, increment or decrement. Third, the count register applies that operation.

Top module: `plc_counter`

## Requirements
- R1: While `rst_n` is low, and after it is released, the count is 0 and the prior-rung registers are 0. In up mode with a positive preset, done is 0.
- R2: Up mode (`mode_i` = 0). A scan tick where `cu_i` is 1 and was 0 at the previous scan tick adds 1. A held `cu_i` adds nothing more, and `cd_i` is ignored.
- R3: Rungs, clear and load act only on a clock edge with `scan_en` high. With `scan_en` low the count holds, and a rung pulse that rises and falls between two scan ticks is never counted.
- R4: In up mode, done is 1 exactly when the count equals the preset.
- R5: Down mode (`mode_i` = 1). A rising `cd_i` at a scan tick subtracts 1, and `cu_i` is ignored. Done is 1 exactly when the count equals 0.
- R6: In down mode, `ld_i` at a scan tick sets the count to `preset_i`, and `clr_i` is ignored.
- R7: Up/down mode (`mode_i` = 2). Rising `cu_i` adds 1 and rising `cd_i` subtracts 1. Both rising in the same scan leaves the count unchanged. Done is 1 when the count is greater than or equal to the preset, compared as signed numbers.
- R8: In up and up/down modes, `clr_i` at a scan tick sets the count to 0, and `ld_i` is ignored.
- R9: When clear or load takes effect in a scan tick, a counting edge in the same tick is discarded.
- R10: The count stops at +32767 when counting up and at -32768 when counting down, and never wraps.
- R11: Mode code 3 behaves exactly as up/down mode.
- R12: Two counters in a chain multiply their ranges. A lower counter with preset 3 has its done bit wired to its own clear and to the upper counter's `cu_i`. Nine lower pulses give an upper count of 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | One-cycle scan tick; all sampling happens on it |
| mode_i | input | 2 | 0 up, 1 down, 2 or 3 up/down |
| cu_i | input | 1 | Count-up rung condition |
| cd_i | input | 1 | Count-down rung condition |
| clr_i | input | 1 | Clear to zero (up and up/down modes) |
| ld_i | input | 1 | Load preset (down mode) |
| preset_i | input | 16 | Signed preset value |
| count_o | output | 16 | Signed current count |
| done_o | output | 1 | Done bit, rule set by mode |

## Verification
Some behaviours are checked by the assertions on every cycle. The count holds whenever no scan tick occurs. Outside clear and load, the count moves by at most one per tick. Clear and load produce their exact values on the next cycle. A count at either limit never wraps to the other one. An edge pulse never repeats on back-to-back cycles. Other behaviours only the bench's scenarios can show: the per-mode done rules, that a held rung is counted once, the cancelling of simultaneous up and down edges, that a pulse between scan ticks is missed, and the cascade of two counters.

// File: rtl/plc_cnt_pkg.sv
package plc_cnt_pkg;

    // Mode codes; code 3 is an alias of the up/down behaviour.
    typedef enum logic [1:0] {
        MODE_UP     = 2'd0,
        MODE_DOWN   = 2'd1,
        MODE_UPDN   = 2'd2,
        MODE_UPDN_X = 2'd3
    } cnt_mode_e;

    // One operation chosen per scan tick.
    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_CLEAR = 3'd1,
        OP_LOAD  = 3'd2,
        OP_INC   = 3'd3,
        OP_DEC   = 3'd4
    } cnt_op_e;

    localparam int unsigned RUNG_UP   = 0;
    localparam int unsigned RUNG_DOWN = 1;
    localparam int unsigned NUM_RUNGS = 2;

endpackage

// File: rtl/plc_cnt_edge.sv
module plc_cnt_edge #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         scan_en,
    input  logic [N-1:0] rung_i,
    output logic [N-1:0] rise_o
);

    logic [N-1:0] prior_q;

    for (genvar g = 0; g < N; g++) begin : g_rung
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prior_q[g] <= 1'b0;
            end else if (scan_en) begin
                prior_q[g] <= rung_i[g];
            end
        end

        assign rise_o[g] = scan_en & rung_i[g] & ~prior_q[g];

        // R2: an edge pulse cannot repeat on the next cycle while the rung is held
        p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
            rise_o[g] |=> !rise_o[g]);
    end

endmodule

// File: rtl/plc_cnt_decode.sv
module plc_cnt_decode
    import plc_cnt_pkg::*;
(
    input  logic      scan_en,
    input  cnt_mode_e mode,
    input  logic      rise_up,
    input  logic      rise_dn,
    input  logic      clr,
    input  logic      ld,
    output cnt_op_e   op
);

    always_comb begin
        op = OP_HOLD;
        if (scan_en) begin
            unique case (mode)
                MODE_UP: begin
                    if (clr)          op = OP_CLEAR;
                    else if (rise_up) op = OP_INC;
                end
                MODE_DOWN: begin
                    if (ld)           op = OP_LOAD;
                    else if (rise_dn) op = OP_DEC;
                end
                MODE_UPDN, MODE_UPDN_X: begin
                    if (clr)                      op = OP_CLEAR;
                    else if (rise_up && !rise_dn) op = OP_INC;
                    else if (rise_dn && !rise_up) op = OP_DEC;
                end
                default: op = OP_HOLD;
            endcase
        end
    end

endmodule

// File: rtl/plc_cnt_core.sv
module plc_cnt_core
    import plc_cnt_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  cnt_op_e                 op,
    input  logic signed [CNT_W-1:0] preset,
    output logic signed [CNT_W-1:0] count
);

    localparam logic signed [CNT_W-1:0] CNT_MAX = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic signed [CNT_W-1:0] CNT_MIN = {1'b1, {(CNT_W-1){1'b0}}};
    localparam logic signed [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic signed [CNT_W-1:0] count_q;
    logic signed [CNT_W-1:0] count_d;

    always_comb begin
        count_d = count_q;
        unique case (op)
            OP_HOLD:  count_d = count_q;
            OP_CLEAR: count_d = '0;
            OP_LOAD:  count_d = preset;
            OP_INC:   count_d = (count_q == CNT_MAX) ? count_q : count_q + CNT_ONE;
            OP_DEC:   count_d = (count_q == CNT_MIN) ? count_q : count_q - CNT_ONE;
            default:  count_d = count_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;

    // R10: the top limit never wraps to the bottom one, nor the reverse
    p_no_wrap_top_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == CNT_MAX && op != OP_LOAD && op != OP_CLEAR) |=> count_q != CNT_MIN);
    p_no_wrap_bot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == CNT_MIN && op != OP_LOAD && op != OP_CLEAR) |=> count_q != CNT_MAX);

endmodule

// File: rtl/plc_cnt_done.sv
module plc_cnt_done
    import plc_cnt_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  cnt_mode_e               mode,
    input  logic signed [CNT_W-1:0] count,
    input  logic signed [CNT_W-1:0] preset,
    output logic                    done
);

    always_comb begin
        done = 1'b0;
        unique case (mode)
            MODE_UP:                done = (count == preset);
            MODE_DOWN:              done = (count == '0);
            MODE_UPDN, MODE_UPDN_X: done = (count >= preset);
            default:                done = 1'b0;
        endcase
    end

endmodule

// File: rtl/plc_counter.sv
module plc_counter
    import plc_cnt_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scan_en,
    input  logic [1:0]              mode_i,
    input  logic                    cu_i,
    input  logic                    cd_i,
    input  logic                    clr_i,
    input  logic                    ld_i,
    input  logic signed [CNT_W-1:0] preset_i,
    output logic signed [CNT_W-1:0] count_o,
    output logic                    done_o
);

    localparam logic signed [CNT_W-1:0] STEP = {{(CNT_W-1){1'b0}}, 1'b1};

    cnt_mode_e              mode;
    logic [NUM_RUNGS-1:0]   rungs;
    logic [NUM_RUNGS-1:0]   rises;
    cnt_op_e                op;
    logic signed [CNT_W-1:0] count;

    assign mode             = cnt_mode_e'(mode_i);
    assign rungs[RUNG_UP]   = cu_i;
    assign rungs[RUNG_DOWN] = cd_i;

    plc_cnt_edge #(.N(NUM_RUNGS)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .scan_en (scan_en),
        .rung_i  (rungs),
        .rise_o  (rises)
    );

    plc_cnt_decode u_decode (
        .scan_en (scan_en),
        .mode    (mode),
        .rise_up (rises[RUNG_UP]),
        .rise_dn (rises[RUNG_DOWN]),
        .clr     (clr_i),
        .ld      (ld_i),
        .op      (op)
    );

    plc_cnt_core #(.CNT_W(CNT_W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .preset (preset_i),
        .count  (count)
    );

    plc_cnt_done #(.CNT_W(CNT_W)) u_done (
        .mode   (mode),
        .count  (count),
        .preset (preset_i),
        .done   (done_o)
    );

    assign count_o = count;

    // R3: no scan tick, no change
    p_hold_without_scan_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |=> $stable(count_o));

    // R8: clear outside down mode yields zero
    p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && clr_i && mode_i != 2'd1) |=> count_o == '0);

    // R6: load in down mode yields the preset
    p_load_preset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && ld_i && mode_i == 2'd1) |=> count_o == $past(preset_i));

    // R2: without clear or load a tick moves the count by at most one
    p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && !clr_i && !ld_i) |=>
            (count_o == $past(count_o) || count_o == $past(count_o) + STEP
             || count_o == $past(count_o) - STEP));

endmodule

// File: tb/plc_counter_tb.sv
module plc_counter_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scan_en = 1'b0;
    logic [1:0] mode = 2'd0;
    logic cu = 1'b0, cd = 1'b0, clr = 1'b0, ld = 1'b0;
    logic signed [15:0] preset = 16'sd0;
    logic signed [15:0] count;
    logic done;

    // cascade second stage
    logic lo_cu = 1'b0;
    logic signed [15:0] lo_count, hi_count;
    logic lo_done, hi_done;

    int applied = 0;
    int miscompares = 0;

    always #10 clk = ~clk;

    plc_counter u_dut (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .mode_i(mode),
        .cu_i(cu), .cd_i(cd), .clr_i(clr), .ld_i(ld), .preset_i(preset),
        .count_o(count), .done_o(done)
    );

    plc_counter u_dut_lo (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .mode_i(2'd0),
        .cu_i(lo_cu), .cd_i(1'b0), .clr_i(lo_done), .ld_i(1'b0), .preset_i(16'sd3),
        .count_o(lo_count), .done_o(lo_done)
    );

    plc_counter u_dut_hi (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .mode_i(2'd0),
        .cu_i(lo_done), .cd_i(1'b0), .clr_i(1'b0), .ld_i(1'b0), .preset_i(16'sd3),
        .count_o(hi_count), .done_o(hi_done)
    );

    // Vector: {req[4], mode[2], cu, cd, clr, ld, preset[16], exp_count[16], exp_done}
    localparam int NV = 38;
    localparam logic [42:0] VEC [0:NV-1] = '{
        {4'd2,  2'd0, 4'b1000, 16'h0003, 16'h0001, 1'b0}, // R2 first edge
        {4'd2,  2'd0, 4'b1000, 16'h0003, 16'h0001, 1'b0}, // R2 held level
        {4'd2,  2'd0, 4'b0000, 16'h0003, 16'h0001, 1'b0},
        {4'd2,  2'd0, 4'b1100, 16'h0003, 16'h0002, 1'b0}, // R2 cd ignored
        {4'd2,  2'd0, 4'b0000, 16'h0003, 16'h0002, 1'b0},
        {4'd4,  2'd0, 4'b1000, 16'h0003, 16'h0003, 1'b1}, // R4 equal
        {4'd4,  2'd0, 4'b0000, 16'h0003, 16'h0003, 1'b1},
        {4'd4,  2'd0, 4'b1000, 16'h0003, 16'h0004, 1'b0}, // R4 above -> off
        {4'd8,  2'd0, 4'b0010, 16'h0003, 16'h0000, 1'b0}, // R8 clear
        {4'd8,  2'd0, 4'b1001, 16'h0003, 16'h0001, 1'b0}, // R8 load ignored
        {4'd8,  2'd0, 4'b0000, 16'h0003, 16'h0001, 1'b0},
        {4'd9,  2'd0, 4'b1010, 16'h0003, 16'h0000, 1'b0}, // R9 clear beats edge
        {4'd9,  2'd0, 4'b0000, 16'h0003, 16'h0000, 1'b0},
        {4'd6,  2'd1, 4'b0001, 16'h0002, 16'h0002, 1'b0}, // R6 load
        {4'd5,  2'd1, 4'b0100, 16'h0002, 16'h0001, 1'b0}, // R5 decrement
        {4'd5,  2'd1, 4'b0100, 16'h0002, 16'h0001, 1'b0}, // R5 held
        {4'd5,  2'd1, 4'b1000, 16'h0002, 16'h0001, 1'b0}, // R5 cu ignored
        {4'd5,  2'd1, 4'b0100, 16'h0002, 16'h0000, 1'b1}, // R5 zero -> done
        {4'd6,  2'd1, 4'b0010, 16'h0002, 16'h0000, 1'b1}, // R6 clear ignored
        {4'd5,  2'd1, 4'b0100, 16'h0002, 16'hFFFF, 1'b0}, // R5 below zero
        {4'd6,  2'd1, 4'b0001, 16'h0002, 16'h0002, 1'b0}, // R6 reload
        {4'd9,  2'd1, 4'b0101, 16'h0002, 16'h0002, 1'b0}, // R9 load beats edge
        {4'd9,  2'd1, 4'b0000, 16'h0002, 16'h0002, 1'b0},
        {4'd7,  2'd2, 4'b1000, 16'h0001, 16'h0003, 1'b1}, // R7 up
        {4'd7,  2'd2, 4'b0100, 16'h0001, 16'h0002, 1'b1}, // R7 down
        {4'd7,  2'd2, 4'b0000, 16'h0001, 16'h0002, 1'b1},
        {4'd7,  2'd2, 4'b1100, 16'h0001, 16'h0002, 1'b1}, // R7 cancel
        {4'd7,  2'd2, 4'b0000, 16'h0001, 16'h0002, 1'b1},
        {4'd7,  2'd2, 4'b0100, 16'h0001, 16'h0001, 1'b1}, // R7 equal -> on
        {4'd7,  2'd2, 4'b0000, 16'h0001, 16'h0001, 1'b1},
        {4'd7,  2'd2, 4'b0100, 16'h0001, 16'h0000, 1'b0}, // R7 below -> off
        {4'd11, 2'd3, 4'b0000, 16'h0001, 16'h0000, 1'b0}, // R11 alias
        {4'd11, 2'd3, 4'b1000, 16'h0001, 16'h0001, 1'b1},
        {4'd11, 2'd3, 4'b0100, 16'h0001, 16'h0000, 1'b0},
        {4'd11, 2'd3, 4'b0010, 16'h0001, 16'h0000, 1'b0},
        {4'd8,  2'd2, 4'b1001, 16'h0001, 16'h0001, 1'b1}, // R8 load ignored
        {4'd8,  2'd2, 4'b0010, 16'h0001, 16'h0000, 1'b0}, // R8 clear
        {4'd7,  2'd2, 4'b0000, 16'hFFFE, 16'h0000, 1'b1}  // R7 signed compare
    };

    task automatic check(input string req, input logic [15:0] got_c, input logic [15:0] exp_c,
                         input logic got_d, input logic exp_d);
        applied++;
        if (got_c !== exp_c || got_d !== exp_d) begin
            miscompares++;
            $display("FAIL %s: count=%0d done=%0b expected count=%0d done=%0b",
                     req, $signed(got_c), got_d, $signed(exp_c), exp_d);
        end
    endtask

    // One clock with scan_en high; returns at the following falling edge.
    task automatic scan_tick();
        scan_en = 1'b1;
        @(negedge clk);
        scan_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        {cu, cd, clr, ld, lo_cu} = 5'b0;
        mode = 2'd0;
        preset = 16'sd3;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        do_reset();
        check("R1 reset", count, 16'h0000, done, 1'b0);

        // R3: toggling without scan ticks has no effect
        for (int i = 0; i < 4; i++) begin
            cu = ~cu;
            @(negedge clk);
        end
        check("R3 no scan", count, 16'h0000, done, 1'b0);
        cu = 1'b1;
        scan_tick();
        check("R3 scan edge", count, 16'h0001, done, 1'b0);
        cu = 1'b0; scan_tick();
        cu = 1'b1; @(negedge clk);
        cu = 1'b0; @(negedge clk);
        scan_tick();
        check("R3 missed pulse", count, 16'h0001, done, 1'b0);

        do_reset();
        for (int i = 0; i < NV; i++) begin
            logic [42:0] v;
            v = VEC[i];
            mode   = v[38:37];
            cu     = v[36];
            cd     = v[35];
            clr    = v[34];
            ld     = v[33];
            preset = v[32:17];
            scan_tick();
            check($sformatf("R%0d vector %0d", v[42:39], i), count, v[16:1], done, v[0]);
        end
        {cu, cd, clr, ld} = 4'b0;

        // R10 saturation
        do_reset();
        mode = 2'd1; ld = 1'b1; preset = 16'sd32766; scan_tick();
        ld = 1'b0; mode = 2'd0; cu = 1'b1; scan_tick();
        check("R10 reach max", count, 16'h7FFF, done, 1'b0);
        cu = 1'b0; scan_tick();
        cu = 1'b1; scan_tick();
        check("R10 hold max", count, 16'h7FFF, done, 1'b0);
        cu = 1'b0;
        mode = 2'd1; ld = 1'b1; preset = 16'sh8001; scan_tick();
        ld = 1'b0; cd = 1'b1; scan_tick();
        check("R10 reach min", count, 16'h8000, done, 1'b0);
        cd = 1'b0; scan_tick();
        cd = 1'b1; scan_tick();
        check("R10 hold min", count, 16'h8000, done, 1'b0);
        cd = 1'b0;

        // R12 cascade: nine lower pulses
        do_reset();
        for (int p = 0; p < 9; p++) begin
            lo_cu = 1'b1; scan_tick();
            lo_cu = 1'b0; scan_tick();
        end
        scan_tick();
        check("R12 upper count", hi_count, 16'h0003, hi_done, 1'b1);
        check("R12 lower count", lo_count, 16'h0000, lo_done, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

endmodule